// File: doc/BRIEF.md
# Iterative Alpha-Beta Search Controller

This block walks a game tree of fixed shape (a set number of candidate moves at every node and a set number of plies) and finds the minimax value of the root using alpha-beta pruning. It does not use recursion. Each ply has one slot in a small register stack. A slot holds the pruning window, the index of the child being explored and the best value found so far at that node. The root ply maximizes, and the plies below it alternate between minimizing and maximizing.

The block neither generates moves nor scores positions. When the walk reaches a leaf, it sends out a leaf request that carries the full path of child indices from the root. It then waits for the leaf's signed score on a separate input stream. Both streams use valid/ready. A request stays on the output with its path unchanged until the consumer asserts ready. The block asserts score_ready only while it waits for the score of a request that has been accepted, and it ignores score_valid at all other times, so a score producer may hold off for any number of cycles. A host starts a search with a one-cycle start pulse. When the search is over, done goes high and stays high together with the best root move and its value.

Top module: `ab_search_ctrl`

## Requirements
- R1: After reset, busy, done, req_valid and score_ready are all low.
- R2: A start pulse seen while idle or done launches a new search. A start pulse seen while busy has no effect on the search in progress.
- R3: Bits [k*IW +: IW] of req_path hold the child index chosen at ply k, with the root ply (ply 0) in the least significant field. Each field is below BRANCH. While req_valid is high and req_ready is low, req_valid stays high and req_path does not change.
- R4: score_ready rises only in the cycle after a request was accepted. It stays high until a score is accepted and is never high together with req_valid. score_valid has no effect while score_ready is low.
- R5: Leaves are requested at most once each, in strictly increasing path order with ply 0 as the most significant digit (depth-first, left to right).
- R6: best_value equals the exact minimax value of the tree, with ply 0 maximizing and the plies alternating below it.
- R7: best_move is the lowest root child index whose minimax value equals best_value.
- R8: The window starts at the most negative and the most positive SW-bit value. A node skips its remaining children once its alpha is greater than or equal to its beta. With the defaults, a perfectly ordered tree takes exactly 31 leaf scores. A tree whose leaves all hold the largest value takes 16, and so does a tree whose leaves all hold the smallest value.
- R9: At the end of a search, done is high and busy is low. best_move and best_value hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a search |
| busy | output | 1 | A search is in progress |
| done | output | 1 | The search has finished and the results are valid |
| req_valid | output | 1 | A leaf request is offered |
| req_ready | input | 1 | The consumer takes the leaf request |
| req_path | output | DEPTH*IW | Child index per ply, ply 0 in the lowest field |
| score_valid | input | 1 | A leaf score is offered |
| score_ready | output | 1 | The block waits for a leaf score |
| score_data | input | SW | Signed leaf score |
| best_move | output | IW | Best root child index |
| best_value | output | SW | Minimax value of the root |

## Verification
The bench builds the block with its default values: four children per node, four plies and 32-bit scores. That gives 256 leaves, so the bench can compute the full minimax reduction from a plain table for every random tree. At this size, the known leaf counts of a perfectly ordered tree and of the two extreme-valued trees can be checked exactly. Narrow score ranges produce many ties between root children, which exercises the lowest-index rule for the best move. Full 32-bit random scores, together with trees whose leaves sit at the very ends of the signed range, test the initial window limits.

// File: rtl/ab_search_pkg.sv
`timescale 1ns/1ps
package ab_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_REQ,
    ST_WAIT,
    ST_FOLD,
    ST_DONE
  } ab_state_e;

  typedef enum logic {
    ROLE_MAX = 1'b0,
    ROLE_MIN = 1'b1
  } ab_role_e;

  function automatic ab_role_e ply_role(input logic ply_lsb);
    return ply_lsb ? ROLE_MIN : ROLE_MAX;
  endfunction

endpackage

// File: rtl/ab_fold_unit.sv
`timescale 1ns/1ps
module ab_fold_unit #(
  parameter int SW = 32
) (
  input  ab_search_pkg::ab_role_e role,
  input  logic signed [SW-1:0]    cur_alpha,
  input  logic signed [SW-1:0]    cur_beta,
  input  logic signed [SW-1:0]    cur_best,
  input  logic signed [SW-1:0]    child_val,
  output logic signed [SW-1:0]    nxt_alpha,
  output logic signed [SW-1:0]    nxt_beta,
  output logic signed [SW-1:0]    nxt_best,
  output logic                    improved,
  output logic                    cutoff
);
  import ab_search_pkg::*;

  always_comb begin
    nxt_alpha = cur_alpha;
    nxt_beta  = cur_beta;
    if (role == ROLE_MAX) begin
      improved = child_val > cur_best;
      if (child_val > cur_alpha) nxt_alpha = child_val;
    end else begin
      improved = child_val < cur_best;
      if (child_val < cur_beta) nxt_beta = child_val;
    end
    nxt_best = improved ? child_val : cur_best;
    cutoff   = nxt_alpha >= nxt_beta;
  end

endmodule

// File: rtl/ab_level_stack.sv
`timescale 1ns/1ps
module ab_level_stack #(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int SW    = 32,
  parameter int LW    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [LW-1:0]           wr_lvl,
  input  logic signed [SW-1:0]    wr_alpha,
  input  logic signed [SW-1:0]    wr_beta,
  input  logic signed [SW-1:0]    wr_best,
  input  logic [IW-1:0]           wr_idx,
  input  logic [LW-1:0]           rd_lvl,
  output logic signed [SW-1:0]    rd_alpha,
  output logic signed [SW-1:0]    rd_beta,
  output logic signed [SW-1:0]    rd_best,
  output logic [IW-1:0]           rd_idx,
  output logic [DEPTH*IW-1:0]     path_o
);

  logic signed [SW-1:0] alpha_q [DEPTH];
  logic signed [SW-1:0] beta_q  [DEPTH];
  logic signed [SW-1:0] best_q  [DEPTH];
  logic [IW-1:0]        idx_q   [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        alpha_q[i] <= '0;
        beta_q[i]  <= '0;
        best_q[i]  <= '0;
        idx_q[i]   <= '0;
      end
    end else if (wr_en) begin
      alpha_q[wr_lvl] <= wr_alpha;
      beta_q[wr_lvl]  <= wr_beta;
      best_q[wr_lvl]  <= wr_best;
      idx_q[wr_lvl]   <= wr_idx;
    end
  end

  assign rd_alpha = alpha_q[rd_lvl];
  assign rd_beta  = beta_q[rd_lvl];
  assign rd_best  = best_q[rd_lvl];
  assign rd_idx   = idx_q[rd_lvl];

  for (genvar g = 0; g < DEPTH; g++) begin : g_path
    assign path_o[g*IW +: IW] = idx_q[g];
  end

endmodule

// File: rtl/ab_search_ctrl.sv
`timescale 1ns/1ps
module ab_search_ctrl #(
  parameter int  BRANCH = 4,
  parameter int  DEPTH  = 4,
  parameter int  SW     = 32,
  localparam int IW     = (BRANCH > 1) ? $clog2(BRANCH) : 1,
  localparam int LW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [DEPTH*IW-1:0]     req_path,
  input  logic                    score_valid,
  output logic                    score_ready,
  input  logic signed [SW-1:0]    score_data,
  output logic [IW-1:0]           best_move,
  output logic signed [SW-1:0]    best_value
);
  import ab_search_pkg::*;

  localparam logic signed [SW-1:0] VMIN     = {1'b1, {(SW-1){1'b0}}};
  localparam logic signed [SW-1:0] VMAX     = {1'b0, {(SW-1){1'b1}}};
  localparam logic [LW-1:0]        LVL_LAST = LW'(DEPTH - 1);
  localparam logic [IW-1:0]        IDX_LAST = IW'(BRANCH - 1);

  ab_state_e            state_q;
  logic [LW-1:0]        lvl_q;
  logic signed [SW-1:0] ret_q;
  logic [IW-1:0]        move_q;
  logic signed [SW-1:0] value_q;

  logic                 wr_en;
  logic [LW-1:0]        wr_lvl;
  logic signed [SW-1:0] wr_alpha, wr_beta, wr_best;
  logic [IW-1:0]        wr_idx;
  logic signed [SW-1:0] rd_alpha, rd_beta, rd_best;
  logic [IW-1:0]        rd_idx;
  logic [DEPTH*IW-1:0]  path_w;

  logic signed [SW-1:0] f_alpha, f_beta, f_best;
  logic                 f_improved, f_cut;
  logic                 node_finished;
  logic                 launch;

  ab_level_stack #(
    .DEPTH(DEPTH), .IW(IW), .SW(SW), .LW(LW)
  ) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_lvl   (wr_lvl),
    .wr_alpha (wr_alpha),
    .wr_beta  (wr_beta),
    .wr_best  (wr_best),
    .wr_idx   (wr_idx),
    .rd_lvl   (lvl_q),
    .rd_alpha (rd_alpha),
    .rd_beta  (rd_beta),
    .rd_best  (rd_best),
    .rd_idx   (rd_idx),
    .path_o   (path_w)
  );

  ab_fold_unit #(.SW(SW)) u_fold (
    .role      (ply_role(lvl_q[0])),
    .cur_alpha (rd_alpha),
    .cur_beta  (rd_beta),
    .cur_best  (rd_best),
    .child_val (ret_q),
    .nxt_alpha (f_alpha),
    .nxt_beta  (f_beta),
    .nxt_best  (f_best),
    .improved  (f_improved),
    .cutoff    (f_cut)
  );

  assign node_finished = f_cut || (rd_idx == IDX_LAST);
  assign launch = start && (state_q == ST_IDLE || state_q == ST_DONE);

  // Stack write port: root init on launch, child init on descent, fold on return.
  always_comb begin
    wr_en    = 1'b0;
    wr_lvl   = lvl_q;
    wr_alpha = rd_alpha;
    wr_beta  = rd_beta;
    wr_best  = rd_best;
    wr_idx   = rd_idx;
    if (launch) begin
      wr_en    = 1'b1;
      wr_lvl   = '0;
      wr_alpha = VMIN;
      wr_beta  = VMAX;
      wr_best  = VMIN;
      wr_idx   = '0;
    end else if (state_q == ST_DESC && lvl_q != LVL_LAST) begin
      wr_en    = 1'b1;
      wr_lvl   = lvl_q + LW'(1);
      wr_best  = (ply_role(~lvl_q[0]) == ROLE_MAX) ? VMIN : VMAX;
      wr_idx   = '0;
    end else if (state_q == ST_FOLD) begin
      wr_en    = 1'b1;
      wr_alpha = f_alpha;
      wr_beta  = f_beta;
      wr_best  = f_best;
      wr_idx   = node_finished ? rd_idx : rd_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      ret_q   <= '0;
      move_q  <= '0;
      value_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (launch) begin
            state_q <= ST_DESC;
            lvl_q   <= '0;
            move_q  <= '0;
          end
        end
        ST_DESC: begin
          if (lvl_q == LVL_LAST) state_q <= ST_REQ;
          else                   lvl_q   <= lvl_q + LW'(1);
        end
        ST_REQ: begin
          if (req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (score_valid) begin
            ret_q   <= score_data;
            state_q <= ST_FOLD;
          end
        end
        ST_FOLD: begin
          if (lvl_q == '0 && f_improved) move_q <= rd_idx;
          if (node_finished) begin
            if (lvl_q == '0) begin
              value_q <= f_best;
              state_q <= ST_DONE;
            end else begin
              ret_q <= f_best;
              lvl_q <= lvl_q - LW'(1);
            end
          end else begin
            state_q <= ST_DESC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done        = (state_q == ST_DONE);
  assign req_valid   = (state_q == ST_REQ);
  assign score_ready = (state_q == ST_WAIT);
  assign req_path    = path_w;
  assign best_move   = move_q;
  assign best_value  = value_q;

endmodule

// File: rtl/ab_search_checks.sv
`timescale 1ns/1ps
module ab_search_checks #(
  parameter int BRANCH = 4,
  parameter int DEPTH  = 4,
  parameter int SW     = 32,
  parameter int IW     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [DEPTH*IW-1:0]  req_path,
  input logic                 score_ready,
  input logic [IW-1:0]        best_move,
  input logic [SW-1:0]        best_value
);

  function automatic logic fields_in_range(input logic [DEPTH*IW-1:0] p);
    for (int k = 0; k < DEPTH; k++)
      if (int'(p[k*IW +: IW]) >= BRANCH) return 1'b0;
    return 1'b1;
  endfunction

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_path));

  assert_path_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> fields_in_range(req_path));

  assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && score_ready));

  assert_score_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(score_ready) |-> $past(req_valid && req_ready));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid && !score_ready);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(best_value) && $stable(best_move));

endmodule

bind ab_search_ctrl ab_search_checks #(
  .BRANCH(BRANCH), .DEPTH(DEPTH), .SW(SW), .IW(IW)
) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_path    (req_path),
  .score_ready (score_ready),
  .best_move   (best_move),
  .best_value  (best_value)
);

// File: tb/ab_search_ctrl_test.sv
`timescale 1ns/1ps
module ab_search_ctrl_test;

  localparam int BR    = 4;
  localparam int DP    = 4;
  localparam int SW    = 32;
  localparam int IW    = 2;
  localparam int NLEAF = 256;
  localparam int VMIN  = 32'sh8000_0000;
  localparam int VMAX  = 32'sh7FFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, req_valid, score_ready;
  logic req_ready = 1'b0;
  logic score_valid = 1'b0;
  logic signed [SW-1:0] score_data = '0;
  logic [DP*IW-1:0] req_path;
  logic [IW-1:0] best_move;
  logic signed [SW-1:0] best_value;

  int n_tests = 0;
  int n_fail  = 0;
  int leaf_tab [NLEAF];

  always #10 clk = ~clk;

  ab_search_ctrl #(.BRANCH(BR), .DEPTH(DP), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_path(req_path),
    .score_valid(score_valid), .score_ready(score_ready), .score_data(score_data),
    .best_move(best_move), .best_value(best_value)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int leaf_of(input logic [DP*IW-1:0] p);
    int l = 0;
    for (int k = 0; k < DP; k++) l = l * BR + int'(p[k*IW +: IW]);
    return l;
  endfunction

  // Full minimax by plain bottom-up reduction (ply 0 maximizes).
  task automatic ref_eval(output int rv, output int rm);
    int cur [NLEAF];
    int n = NLEAF;
    rv = 0;
    rm = 0;
    for (int i = 0; i < NLEAF; i++) cur[i] = leaf_tab[i];
    for (int d = DP - 1; d >= 0; d--) begin
      n = n / BR;
      for (int k = 0; k < n; k++) begin
        int acc = cur[k*BR];
        for (int c = 1; c < BR; c++) begin
          if (d % 2 == 0) begin if (cur[k*BR+c] > acc) acc = cur[k*BR+c]; end
          else            begin if (cur[k*BR+c] < acc) acc = cur[k*BR+c]; end
        end
        if (d == 0) begin
          rv = acc;
          rm = -1;
          for (int c = 0; c < BR; c++) if (rm < 0 && cur[c] == acc) rm = c;
        end
        cur[k] = acc;
      end
    end
  endtask

  // mode bit0: random stalls, bit1: handshake noise, bit2: start pulse mid-search
  task automatic run_search(input string name, input int mode, input int exp_leaves);
    int ev, em, leaves, prev, bad_order, cyc, cur_leaf;
    logic snap_rv, snap_sr;
    logic [DP*IW-1:0] snap_path;
    ref_eval(ev, em);
    leaves = 0; prev = -1; bad_order = 0; cyc = 0; cur_leaf = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    snap_rv = 1'b0; snap_sr = 1'b0; snap_path = '0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (snap_rv && req_ready) begin
        cur_leaf = leaf_of(snap_path);
        if (cur_leaf <= prev) bad_order++;
        prev = cur_leaf;
        leaves++;
      end
      if (snap_rv && !req_ready) begin
        // R3: request held until taken
        check("R3", "request held", {req_valid, req_path}, {1'b1, snap_path});
      end
      // R4: request and score phases never overlap
      check("R4", "phase overlap", req_valid && score_ready, 0);
      if (done) break;
      if (cyc > 20000) begin
        check("R9", "search finished", 0, 1);
        break;
      end
      start = ((mode & 4) != 0 && cyc == 40);
      if ((mode & 2) != 0) begin
        req_ready   = 1'b1;
        score_valid = 1'b1;
        score_data  = score_ready ? leaf_tab[cur_leaf] : 32'sh5A5A_A5A5;
      end else begin
        req_ready   = req_valid && (((mode & 1) == 0) || $urandom_range(0, 2) != 0);
        score_valid = score_ready && (((mode & 1) == 0) || $urandom_range(0, 1) != 0);
        score_data  = leaf_tab[cur_leaf];
      end
      snap_rv = req_valid;
      snap_sr = score_ready;
      snap_path = req_path;
    end
    start = 1'b0; req_ready = 1'b0; score_valid = 1'b0;
    check("R6", {name, " root value"}, best_value, ev);
    check("R7", {name, " best move"}, best_move, em);
    check("R5", {name, " leaf order violations"}, bad_order, 0);
    if (exp_leaves >= 0) check("R8", {name, " leaf count"}, leaves, exp_leaves);
    repeat (5) @(negedge clk);
    check("R9", {name, " done held"}, {done, busy}, 2'b10);
    check("R9", {name, " value held"}, best_value, ev);
  endtask

  task automatic fill_random(input int span);
    for (int i = 0; i < NLEAF; i++) leaf_tab[i] = $urandom_range(0, 2*span) - span;
  endtask

  task automatic fill_ordered();
    for (int i = 0; i < NLEAF; i++)
      leaf_tab[i] = -(i/64)*4096 + ((i/16)%4)*256 - ((i/4)%4)*16 + (i%4);
  endtask

  task automatic fill_const(input int v);
    for (int i = 0; i < NLEAF; i++) leaf_tab[i] = v;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outputs in reset", {busy, done, req_valid, score_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset", {busy, done, req_valid, score_ready}, 0);

    fill_ordered();
    run_search("ordered", 0, 31);
    run_search("ordered stalls", 1, 31);
    run_search("ordered start mid-search R2", 4, 31);
    fill_const(VMAX);
    run_search("all max", 0, 16);
    fill_const(VMIN);
    run_search("all min", 1, 16);
    fill_const(7);
    run_search("flat", 0, -1);
    for (int t = 0; t < 6; t++) begin
      fill_random(3 + t * 20);
      run_search("random narrow", t % 3 == 2 ? 2 : 1, -1);
    end
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < NLEAF; i++) leaf_tab[i] = int'($urandom);
      run_search("random wide", t == 1 ? 6 : 1, -1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule